// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Counter

This block estimates the frequency of an unknown clock by counting its rising edges over a window. The window length is a number of reference ticks, where a reference tick is a single-cycle strobe in the bus clock domain (for example, a divided crystal clock). Software controls the block through one control word and reads the result from one status word.

A control write with the run bit clear stops the counting and asks for the edge counter to be cleared. A control write with the run bit set opens a new window that lasts for the number of ticks given in the same write. When the window closes, the edge counter stops. After a fixed settle time in bus cycles, the block captures the count, which crossed into the bus domain in gray code, and raises the done flag.

The edge counter lives entirely in the measured clock domain. It clears, counts and holds only on edges of that clock. As a result, a stopped input leaves the previous count in place, and software can detect a dead clock by running two measurements and comparing them.

Top module: `freq_meter`

## Requirements
- R1: After reset, every bit of the status word reads 0.
- R2: A control write with bit 20 (run) clear makes the done flag read 0 on the next bus cycle, and clears the edge counter once the measured clock has ticked a few times.
- R3: A control write with bit 20 set and a non-zero tick value N in bits TICK_W-1:0 opens a window that closes on the Nth reference tick after the write cycle. A tick that arrives in the write cycle itself is not counted. Done (status bit 25) stays 0 until SETTLE_CYC bus cycles after the window closes.
- R4: When done is 1, status bits CNT_W-1:0 hold the number of measured-clock rising edges within the window, within ±2.
- R5: Done rises exactly SETTLE_CYC bus cycles after the closing tick. Done and the count then stay unchanged until the next control write.
- R6: A start write with tick value 0 counts no edges. Done follows SETTLE_CYC cycles later, and the count reads 0 if a stop write and running clock cleared the counter just before.
- R7: With SATURATE=1, the count stops at all ones in CNT_W bits instead of wrapping.
- R8: If the measured clock is not toggling, the edge counter keeps its value, so a measurement repeats the previous count exactly. Counting resumes normally once the clock runs again.
- R9: Outside a clear, each step of the counter changes at most one bit of its gray-coded copy, so the bus domain never samples a torn value.
- R10: Status bits 31:26, and count bits 24:CNT_W when CNT_W is below 25, always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| ref_tick_i | input | 1 | Single-cycle reference tick strobe, bus domain |
| meas_clk_i | input | 1 | Clock under measurement |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word: ticks in TICK_W-1:0, run at bit 20 |
| status_o | output | 32 | Status word: done at bit 25, count in CNT_W-1:0 |

## Verification
The assertions assume a few things about the inputs:
- The measured clock is fast enough that the stop command and the last gray update complete within the settle window, roughly SETTLE_CYC/4 bus periods or faster.
- Software waits after a stop write long enough for the clear to reach a running clock.
- Reference ticks are single-cycle strobes.

The stimulus stays within these limits. It uses a 10 ns bus clock and measured periods from 4 ns to 25 ns against a 16-cycle settle time. It waits 20 cycles after every stop write, and it aligns each start write to a tick, so the expected window of exactly 4N bus cycles can be computed. The dead-clock case deliberately stops the measured clock, so no command reaches that domain. The bench expects the counter to hold there.

// File: rtl/fm_pkg.sv
`timescale 1ns/100ps
package fm_pkg;
   localparam int unsigned FM_RUN_BIT  = 20;
   localparam int unsigned FM_DONE_BIT = 25;
   localparam int unsigned FM_FIELD_W  = 25;
   localparam int unsigned FM_WORD_W   = 32;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_OPEN   = 2'd1,
      ST_SETTLE = 2'd2,
      ST_DONE   = 2'd3
   } fm_state_e;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/100ps
module fm_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fm_edge_counter.sv
`timescale 1ns/100ps
module fm_edge_counter #(
   parameter int unsigned CNT_W       = 25,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SATURATE    = 1'b1
) (
   input  logic             meas_clk_i,
   input  logic             rst_ni,
   input  logic             run_lvl_i,
   input  logic             clr_lvl_i,
   output logic [CNT_W-1:0] gray_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [1:0]       rst_sync_q;
   logic             m_rst_n;
   logic [1:0]       ctl_s;
   logic             run_s;
   logic             clr_s;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] gray_q;

   // local reset: asserts at once, releases on measured-clock edges
   always_ff @(posedge meas_clk_i or negedge rst_ni) begin
      if (!rst_ni) rst_sync_q <= 2'b00;
      else         rst_sync_q <= {rst_sync_q[0], 1'b1};
   end
   assign m_rst_n = rst_sync_q[1];

   fm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
      .clk_i  (meas_clk_i),
      .rst_ni (m_rst_n),
      .d_i    ({clr_lvl_i, run_lvl_i}),
      .q_o    (ctl_s)
   );
   assign run_s = ctl_s[0];
   assign clr_s = ctl_s[1];

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = cnt_q + 1'b1;
      end
   endgenerate

   always_comb begin
      if (clr_s)      cnt_nxt = '0;
      else if (run_s) cnt_nxt = cnt_inc;
      else            cnt_nxt = cnt_q;
   end

   always_ff @(posedge meas_clk_i or negedge m_rst_n) begin
      if (!m_rst_n) begin
         cnt_q  <= '0;
         gray_q <= '0;
      end else begin
         cnt_q  <= cnt_nxt;
         gray_q <= cnt_nxt ^ (cnt_nxt >> 1);
      end
   end

   assign gray_o = gray_q;

   AST_CLEAR_ZERO: assert property (@(posedge meas_clk_i) disable iff (!m_rst_n)
      clr_s |=> (cnt_q == '0)) else $error("clear did not zero counter"); // R2
   AST_IDLE_HOLD: assert property (@(posedge meas_clk_i) disable iff (!m_rst_n)
      (!run_s && !clr_s) |=> $stable(cnt_q)) else $error("idle counter moved"); // R8
   AST_GRAY_STEP: assert property (@(posedge meas_clk_i) disable iff (!m_rst_n)
      !clr_s |=> ($countones(gray_q ^ $past(gray_q)) <= 1)) else $error("gray step >1 bit"); // R9
   generate
      if (SATURATE) begin : g_sat_chk
         AST_NO_WRAP: assert property (@(posedge meas_clk_i) disable iff (!m_rst_n)
            (run_s && !clr_s && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX))
            else $error("counter wrapped"); // R7
      end
   endgenerate
endmodule

// File: rtl/fm_gray_rx.sv
`timescale 1ns/100ps
module fm_gray_rx #(
   parameter int unsigned CNT_W       = 25,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] gray_i,
   output logic [CNT_W-1:0] bin_o
);
   logic [CNT_W-1:0] gray_s;

   fm_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_gray_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (gray_i),
      .q_o    (gray_s)
   );

   always_comb begin
      for (int i = 0; i < CNT_W; i++) bin_o[i] = ^(gray_s >> i);
   end
endmodule

// File: rtl/fm_window.sv
`timescale 1ns/100ps
module fm_window
   import fm_pkg::*;
#(
   parameter int unsigned TICK_W     = 20,
   parameter int unsigned CNT_W      = 25,
   parameter int unsigned SETTLE_CYC = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ctl_we_i,
   input  logic [TICK_W-1:0] ctl_ticks_i,
   input  logic              ctl_run_i,
   input  logic              ref_tick_i,
   input  logic [CNT_W-1:0]  meas_bin_i,
   output logic              run_lvl_o,
   output logic              clr_lvl_o,
   output logic              done_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
   localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

   fm_state_e         state_q;
   logic [TICK_W-1:0] tick_q;
   logic [SW-1:0]     settle_q;
   logic              run_q;
   logic              clr_q;
   logic              done_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         tick_q   <= '0;
         settle_q <= '0;
         run_q    <= 1'b0;
         clr_q    <= 1'b0;
         done_q   <= 1'b0;
         cnt_q    <= '0;
      end else if (ctl_we_i) begin
         tick_q   <= ctl_ticks_i;
         settle_q <= '0;
         done_q   <= 1'b0;
         if (ctl_run_i) begin
            clr_q <= 1'b0;
            if (ctl_ticks_i == '0) begin
               run_q   <= 1'b0;
               state_q <= ST_SETTLE;
            end else begin
               run_q   <= 1'b1;
               state_q <= ST_OPEN;
            end
         end else begin
            clr_q   <= 1'b1;
            run_q   <= 1'b0;
            state_q <= ST_IDLE;
         end
      end else begin
         case (state_q)
            ST_OPEN: begin
               if (ref_tick_i) begin
                  if (tick_q == TICK_W'(1)) begin
                     run_q   <= 1'b0;
                     state_q <= ST_SETTLE;
                  end
                  tick_q <= tick_q - 1'b1;
               end
            end
            ST_SETTLE: begin
               if (settle_q == SETTLE_LAST) begin
                  cnt_q   <= meas_bin_i;
                  done_q  <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  settle_q <= settle_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign run_lvl_o = run_q;
   assign clr_lvl_o = clr_q;
   assign done_o    = done_q;
   assign cnt_o     = cnt_q;

   AST_STOP_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_we_i && !ctl_run_i) |=> (!done_q && clr_q && !run_q)) else $error("stop write"); // R2
   AST_DONE_WINDOW_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> !run_q) else $error("done while window open"); // R3
   AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_q && !ctl_we_i) |=> (done_q && $stable(cnt_q))) else $error("result moved"); // R5
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/100ps
module freq_meter
   import fm_pkg::*;
#(
   parameter int unsigned TICK_W      = 20,
   parameter int unsigned CNT_W       = 25,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SETTLE_CYC  = 16,
   parameter bit          SATURATE    = 1'b1
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        ref_tick_i,
   input  logic        meas_clk_i,
   input  logic        ctl_we_i,
   input  logic [31:0] ctl_wdata_i,
   output logic [31:0] status_o
);
   generate
      if (TICK_W < 1 || TICK_W > FM_RUN_BIT) begin : g_bad_tick
         $error("TICK_W must lie in 1..20");
      end
      if (CNT_W < 2 || CNT_W > FM_FIELD_W) begin : g_bad_cnt
         $error("CNT_W must lie in 2..25");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SETTLE_CYC < 4) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 4");
      end
   endgenerate

   logic             run_lvl;
   logic             clr_lvl;
   logic             done;
   logic [CNT_W-1:0] cnt_cap;
   logic [CNT_W-1:0] meas_gray;
   logic [CNT_W-1:0] meas_bin;
   logic [31:0]      wdata_unused;

   assign wdata_unused = ctl_wdata_i;

   fm_window #(
      .TICK_W     (TICK_W),
      .CNT_W      (CNT_W),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_window (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctl_we_i    (ctl_we_i),
      .ctl_ticks_i (ctl_wdata_i[TICK_W-1:0]),
      .ctl_run_i   (ctl_wdata_i[FM_RUN_BIT]),
      .ref_tick_i  (ref_tick_i),
      .meas_bin_i  (meas_bin),
      .run_lvl_o   (run_lvl),
      .clr_lvl_o   (clr_lvl),
      .done_o      (done),
      .cnt_o       (cnt_cap)
   );

   fm_edge_counter #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES),
      .SATURATE    (SATURATE)
   ) u_edge_counter (
      .meas_clk_i (meas_clk_i),
      .rst_ni     (rst_ni),
      .run_lvl_i  (run_lvl),
      .clr_lvl_i  (clr_lvl),
      .gray_o     (meas_gray)
   );

   fm_gray_rx #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_gray_rx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .gray_i (meas_gray),
      .bin_o  (meas_bin)
   );

   always_comb begin
      status_o              = '0;
      status_o[FM_DONE_BIT] = done;
      status_o[CNT_W-1:0]   = cnt_cap;
   end
endmodule

// File: tb/freq_meter_bench.sv
`timescale 1ns/100ps
module freq_meter_bench;
   localparam int CLK_PERIOD_NS = 10;
   localparam int TICK_W        = 12;
   localparam int CNT_W         = 10;
   localparam int SETTLE        = 16;
   localparam int CNT_MAX       = (1 << CNT_W) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        meas_clk = 1'b0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic [31:0] status_o;

   realtime meas_half = 2.0;
   bit      meas_on = 1'b1;
   int      ph = 0;
   int      n_vec = 0;
   int      n_bad = 0;

   freq_meter #(
      .TICK_W     (TICK_W),
      .CNT_W      (CNT_W),
      .SETTLE_CYC (SETTLE)
   ) u_freq_meter (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ref_tick_i  (ref_tick),
      .meas_clk_i  (meas_clk),
      .ctl_we_i    (ctl_we),
      .ctl_wdata_i (ctl_wdata),
      .status_o    (status_o)
   );

   initial forever #(CLK_PERIOD_NS / 2) clk = ~clk;

   initial begin
      forever begin
         if (meas_on) #(meas_half) meas_clk = ~meas_clk;
         else         #1;
      end
   end

   // reference tick: one bus cycle in four
   always @(negedge clk) begin
      ph = (ph + 1) % 4;
      ref_tick = (ph == 0);
   end

   task automatic check(input string req, input int act, input int exp, input int tol);
      int d;
      n_vec++;
      d = (act > exp) ? act - exp : exp - act;
      if (d > tol) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
      end
   endtask

   task automatic ctl_write(input bit run, input int ticks, input bit align);
      if (align) begin
         do begin @(negedge clk); #1; end while (ph != 0);
      end else begin
         @(negedge clk); #1;
      end
      ctl_we = 1'b1;
      ctl_wdata = '0;
      ctl_wdata[TICK_W-1:0] = ticks[TICK_W-1:0];
      ctl_wdata[20] = run;
      @(negedge clk); #1;
      ctl_we = 1'b0;
      ctl_wdata = '0;
   endtask

   task automatic measure(input int half_t, input int n, input bit clk_on, output int cnt);
      meas_half = half_t * 0.1;
      meas_on = clk_on;
      ctl_write(1'b0, 0, 1'b0);
      check("R2 done after stop", int'(status_o[25]), 0, 0);
      repeat (20) @(negedge clk);
      ctl_write(1'b1, n, 1'b1);
      repeat (4 * n + SETTLE - 1) @(negedge clk);
      #1;
      check("R3 done early", int'(status_o[25]), 0, 0);
      @(negedge clk); #1;
      check("R5 done timing", int'(status_o[25]), 1, 0);
      check("R10 zero bits", int'(status_o[31:26]) + int'(status_o[24:CNT_W]), 0, 0);
      cnt = int'(status_o[CNT_W-1:0]);
      repeat (10) @(negedge clk);
      #1;
      check("R5 result hold", int'(status_o[CNT_W-1:0]) + 4096 * int'(status_o[25]), cnt + 4096, 0);
   endtask

   function automatic int expect_cnt(input int half_t, input int n);
      return (n * 4 * CLK_PERIOD_NS * 10) / (2 * half_t);
   endfunction

   initial begin
      #(CLK_PERIOD_NS * 200000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int halves [4] = '{20, 35, 65, 125};
      int lens   [4] = '{1, 7, 32, 100};
      int c, c_prev;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R1 reset status", int'(status_o), 0, 0);

      // sweep: frequency x window length; R4 count, R9 clean crossing
      foreach (halves[i]) begin
         foreach (lens[j]) begin
            measure(halves[i], lens[j], 1'b1, c);
            check("R4 R9 count", c, expect_cnt(halves[i], lens[j]), 2);
         end
      end

      measure(20, 0, 1'b1, c);
      check("R6 zero window", c, 0, 0);

      measure(20, 200, 1'b1, c);
      check("R7 saturate", c, CNT_MAX, 0);

      measure(35, 32, 1'b1, c_prev);
      check("R4 before dead", c_prev, expect_cnt(35, 32), 2);
      measure(35, 32, 1'b0, c);
      check("R8 dead clock repeats", c, c_prev, 0);
      measure(65, 7, 1'b1, c);
      check("R8 recovery", c, expect_cnt(65, 7), 2);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule